// File: doc/BRIEF.md
# CD Sector Buffer Controller Host Register Port

This block is the host side of a CD sector buffer controller. The host first loads a register index and then moves 8-bit data to or from the register at that index. After each access the index moves on by itself, so the host can walk through a run of registers with repeated strobes. Index 0 is the exception: it stays where it is.

The port holds the following state:
- the interface control and interface status registers;
- the two decode control registers and the decode status registers;
- the transfer byte count and the transfer address;
- the block pointer and the write address;
- the main header and the sub-header captured from the last decoded block.

The separate transfer engine and sector decoder are reached only through single-cycle strobes. The port sends a start strobe to the engine. It receives a done strobe from the engine and a block-done strobe, with header words, from the decoder.

Two pending conditions can interrupt the host: transfer end and decoder done. Each has its own enable. They are merged into one active-low interrupt line. When the merged condition goes from none to some while the external gate is open, the port raises a one-clock request pulse toward the host interrupt controller. Some reads and writes have side effects:
- reading the last decode status register acknowledges the decoder interrupt;
- writing the acknowledge index clears the transfer-end interrupt;
- writing the top index restores every register to its reset value.

Top module: `cdreg_port`

## Requirements
- R1: When idx_ld is high, the index takes idx_in. A read or write strobe at a nonzero index advances the index by one, wrapping modulo 2^IDX_W (IDX_W defaults to 4). A strobe at index 0 leaves the index at 0. The current index is shown on idx_o.
- R2: After reset the following values hold:
  - interface status (index 1) reads 0xFF;
  - decode status 3 (index 15) reads 0x80;
  - main header byte 3 (index 7) reads 0x01;
  - rd_data, idx_o, irq_req and xfer_start are 0, and irq_n is 1.
- R3: Writing interface control (index 1) has these effects on interface status, whose flags are active-low (bit 6 transfer-end pending, bit 5 decoder pending, bit 3 busy, bit 1 enabled):
  - with bit 1 (output enable) clear, it forces status bits 3 and 1 high;
  - a later write to index 6 with output enable set drives status bits 3 and 1 low and pulses xfer_start for one clock;
  - a write to index 6 with output enable clear has no effect.
- R4: An xfer_done strobe drives status bits 3 and 1 high and status bit 6 low.
- R5: A dec_done strobe while decode control 0 bit 7 is set has these effects:
  - it loads dec_hdr into the main header and dec_sub into the sub-header (byte k is bits 8k+7:8k);
  - it writes 0x00 to decode status 3;
  - it drives status bit 5 low.
  While decode control 0 bit 7 is clear, the strobe has no effect.
- R6: irq_n is low exactly when (~status & control & 0x60) is nonzero.
- R7: irq_req is a one-clock pulse. It starts one clock after the interrupt condition of R6 goes from zero to nonzero, and only if gate_en is high. It never fires while gate_en is low.
- R8: Reading index 15 returns decode status 3 as it stood. The read then sets that register to 0x80 and drives status bit 5 high.
- R9: Writing index 7 drives status bit 6 high, which clears the transfer-end interrupt.
- R10: Writing index 15 restores all registers to their reset values, and the index becomes 0.
- R11: Reads at indices 4 to 7 return header bytes 0 to 3. They come from the main header when decode control 1 (index 11) bit 0 is clear, and from the sub-header when it is set.
- R12: Decode status 2 (read at index 14) is recomputed on every write to index 10 or index 11, and on every accepted dec_done while auto mode is set.
  - With auto mode (decode control 0 bit 4) set, bit 3 is decode control 1 bit 3 and bit 2 is sub-header byte 2 bit 5.
  - With auto mode clear, it is decode control 1 masked to bits 3 and 2.
- R13: The following registers and reads behave as shown.

  | Index | Access | Behaviour |
  |---|---|---|
  | 2 | read and write | byte count bits 7:0 |
  | 3 | write | keeps only bits 3:0, stored as byte count bits 11:8 |
  | 3 | read | byte count bits 11:8, upper four bits zero |
  | 4 | write | transfer address bits 7:0 |
  | 5 | write | transfer address bits 15:8 |
  | 12 | read | decode control 0 ANDed with 0x80 |
  | 13 | read | always 0x00 |
  | 0 | read | 0xFF (unmapped) |

  The byte count appears on xfer_count and the transfer address on xfer_addr.
- R14: rd_data updates on the clock edge that samples rd_stb. It then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_ld | input | 1 | Load the register index |
| idx_in | input | IDX_W | Index value to load |
| rd_stb | input | 1 | Single-cycle register read strobe |
| wr_stb | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| idx_o | output | IDX_W | Current register index |
| gate_en | input | 1 | External interrupt gate enable |
| xfer_done | input | 1 | Transfer engine finished strobe |
| dec_done | input | 1 | Decoder block finished strobe |
| dec_hdr | input | 32 | Header of the decoded block |
| dec_sub | input | 32 | Sub-header of the decoded block |
| xfer_start | output | 1 | Transfer start strobe to the engine |
| xfer_count | output | 12 | Transfer byte count |
| xfer_addr | output | 16 | Transfer address |
| irq_n | output | 1 | Merged active-low interrupt |
| irq_req | output | 1 | One-clock interrupt request pulse |

## Verification
The assertions assume the following about the inputs:
- an index load never coincides with a data strobe;
- the engine and decoder strobes never land in the same cycle as a host access that touches the same status bits, because host updates take priority there.

The stimulus drives exactly one strobe per clock from the falling edge, so every property sees a single cause per cycle. Interrupt sweeps set up each pending state through the decoder and engine strobes alone, with no host access in the same cycle.

// File: rtl/cdreg_pkg.sv
package cdreg_pkg;

  localparam logic [7:0] ST_TEND = 8'h40;
  localparam logic [7:0] ST_DEC  = 8'h20;
  localparam logic [7:0] ST_BUSY = 8'h08;
  localparam logic [7:0] ST_ENA  = 8'h02;
  localparam logic [7:0] IRQ_MSK = 8'h60;

  localparam logic [3:0] RX_STAT = 4'd1;
  localparam logic [3:0] RX_CNTL = 4'd2;
  localparam logic [3:0] RX_CNTH = 4'd3;
  localparam logic [3:0] WX_ADRL = 4'd4;
  localparam logic [3:0] WX_ADRH = 4'd5;
  localparam logic [3:0] WX_TRIG = 4'd6;
  localparam logic [3:0] WX_ACK  = 4'd7;
  localparam logic [3:0] WX_WAL  = 4'd8;
  localparam logic [3:0] WX_WAH  = 4'd9;
  localparam logic [3:0] WX_DC0  = 4'd10;
  localparam logic [3:0] WX_DC1  = 4'd11;
  localparam logic [3:0] WX_PTL  = 4'd12;
  localparam logic [3:0] WX_PTH  = 4'd13;
  localparam logic [3:0] RX_DS2  = 4'd14;
  localparam logic [3:0] X_TOP   = 4'd15;

  typedef struct packed {
    logic [7:0]  ifs;
    logic [7:0]  ifc;
    logic [11:0] cnt;
    logic [15:0] adr;
    logic [15:0] ptr;
    logic [15:0] wad;
    logic [7:0]  dc0;
    logic [7:0]  dc1;
    logic [7:0]  ds0;
    logic [7:0]  ds2;
    logic [7:0]  ds3;
    logic [31:0] hdm;
    logic [31:0] hds;
  } regs_t;

  localparam regs_t REGS_RST = '{
    ifs: 8'hFF, ifc: 8'h00, cnt: 12'h000, adr: 16'h0000,
    ptr: 16'h0000, wad: 16'h0000, dc0: 8'h00, dc1: 8'h00,
    ds0: 8'h00, ds2: 8'h00, ds3: 8'h80,
    hdm: 32'h0100_0000, hds: 32'h0000_0000
  };

  function automatic logic [7:0] stat2_f(input logic auto_md,
                                         input logic [1:0] c1_mf,
                                         input logic sub_form);
    return auto_md ? {4'b0, c1_mf[1], sub_form, 2'b0}
                   : {4'b0, c1_mf, 2'b0};
  endfunction

  function automatic logic [7:0] irq_state_f(input logic [7:0] ifs,
                                             input logic [7:0] ifc);
    return ~ifs & ifc & IRQ_MSK;
  endfunction

endpackage

// File: rtl/cdreg_index.sv
module cdreg_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             access,
  input  logic             clr,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idx <= '0;
    else if (ld)                idx <= ld_val;
    else if (clr)               idx <= '0;
    else if (access && !at_zero) idx <= idx + ONE;
  end

  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ld && !clr && !at_zero) |=> (idx == $past(idx) + ONE));
  // R1
  idx_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ld && !clr && at_zero) |=> (idx == '0));
  // R10
  idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> (idx == '0));

endmodule

// File: rtl/cdreg_irq.sv
module cdreg_irq
  import cdreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ifs,
  input  logic [7:0] ifc,
  input  logic       gate_en,
  output logic       irq_n,
  output logic       irq_req
);

  logic [7:0] int_state;
  logic       int_any;
  logic       int_prev;

  assign int_state = irq_state_f(ifs, ifc);
  assign int_any   = |int_state;
  assign irq_n     = ~int_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_prev <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      int_prev <= int_any;
      irq_req  <= gate_en && int_any && !int_prev;
    end
  end

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(gate_en) && $past(int_any)));

endmodule

// File: rtl/cdreg_file.sv
module cdreg_file
  import cdreg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic             xfer_done,
  input  logic             dec_done,
  input  logic [31:0]      dec_hdr,
  input  logic [31:0]      dec_sub,
  output logic [7:0]       rd_data,
  output logic [7:0]       ifs_o,
  output logic [7:0]       ifc_o,
  output logic [11:0]      cnt_o,
  output logic [15:0]      adr_o,
  output logic             xfer_start,
  output logic             soft_rst
);

  regs_t r, nxt;
  logic       hi_ok;
  logic [3:0] lo;
  logic       wr_hit, rd_hit, dec_fire, start_c;
  logic [7:0] rd_mux;
  logic [31:0] hsel;

  generate
    if (IDX_W > 4) begin : g_wide
      assign hi_ok = ~|idx[IDX_W-1:4];
    end else begin : g_narrow
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign lo       = idx[3:0];
  assign wr_hit   = wr_stb && hi_ok;
  assign rd_hit   = rd_stb && hi_ok;
  assign dec_fire = dec_done && r.dc0[7];
  assign soft_rst = wr_hit && (lo == X_TOP);

  always_comb begin
    nxt     = r;
    start_c = 1'b0;
    if (xfer_done) begin
      nxt.ifs = (nxt.ifs | ST_BUSY | ST_ENA) & ~ST_TEND;
    end
    if (dec_fire) begin
      nxt.hdm = dec_hdr;
      nxt.hds = dec_sub;
      nxt.ds3 = 8'h00;
      nxt.ifs = nxt.ifs & ~ST_DEC;
      if (r.dc0[4]) nxt.ds2 = stat2_f(1'b1, r.dc1[3:2], dec_sub[21]);
    end
    if (wr_hit) begin
      case (lo)
        RX_STAT: begin
          nxt.ifc = wr_data;
          if (!wr_data[1]) nxt.ifs = nxt.ifs | ST_BUSY | ST_ENA;
        end
        RX_CNTL: nxt.cnt[7:0]  = wr_data;
        RX_CNTH: nxt.cnt[11:8] = wr_data[3:0];
        WX_ADRL: nxt.adr[7:0]  = wr_data;
        WX_ADRH: nxt.adr[15:8] = wr_data;
        WX_TRIG: begin
          if (r.ifc[1]) begin
            nxt.ifs = nxt.ifs & ~(ST_BUSY | ST_ENA);
            start_c = 1'b1;
          end
        end
        WX_ACK:  nxt.ifs = nxt.ifs | ST_TEND;
        WX_WAL:  nxt.wad[7:0]  = wr_data;
        WX_WAH:  nxt.wad[15:8] = wr_data;
        WX_DC0: begin
          nxt.dc0 = wr_data;
          nxt.ds0 = wr_data & 8'h80;
          nxt.ds2 = stat2_f(wr_data[4], r.dc1[3:2], r.hds[21]);
        end
        WX_DC1: begin
          nxt.dc1 = wr_data;
          nxt.ds2 = stat2_f(r.dc0[4], wr_data[3:2], r.hds[21]);
        end
        WX_PTL:  nxt.ptr[7:0]  = wr_data;
        WX_PTH:  nxt.ptr[15:8] = wr_data;
        X_TOP:   nxt = REGS_RST;
        default: ;
      endcase
    end
    if (rd_hit && (lo == X_TOP)) begin
      nxt.ds3 = 8'h80;
      nxt.ifs = nxt.ifs | ST_DEC;
    end
  end

  assign hsel = r.dc1[0] ? r.hds : r.hdm;

  always_comb begin
    rd_mux = 8'hFF;
    if (hi_ok) begin
      case (lo)
        4'd1:  rd_mux = r.ifs;
        4'd2:  rd_mux = r.cnt[7:0];
        4'd3:  rd_mux = {4'h0, r.cnt[11:8]};
        4'd4:  rd_mux = hsel[7:0];
        4'd5:  rd_mux = hsel[15:8];
        4'd6:  rd_mux = hsel[23:16];
        4'd7:  rd_mux = hsel[31:24];
        4'd8:  rd_mux = r.ptr[7:0];
        4'd9:  rd_mux = r.ptr[15:8];
        4'd10: rd_mux = r.wad[7:0];
        4'd11: rd_mux = r.wad[15:8];
        4'd12: rd_mux = r.ds0;
        4'd13: rd_mux = 8'h00;
        4'd14: rd_mux = r.ds2;
        4'd15: rd_mux = r.ds3;
        default: rd_mux = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r          <= REGS_RST;
      rd_data    <= 8'h00;
      xfer_start <= 1'b0;
    end else begin
      r          <= nxt;
      xfer_start <= start_c;
      if (rd_stb) rd_data <= rd_mux;
    end
  end

  assign ifs_o = r.ifs;
  assign ifc_o = r.ifc;
  assign cnt_o = r.cnt;
  assign adr_o = r.adr;

  // R8
  ds3_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && lo == X_TOP && !wr_stb && !dec_fire) |=> (r.ds3 == 8'h80 && r.ifs[5]));
  // R9
  tend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lo == WX_ACK && !xfer_done) |=> r.ifs[6]);
  // R3
  out_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lo == RX_STAT && !wr_data[1]) |=> (r.ifs[3] && r.ifs[1] && !xfer_start));
  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (r.ifs == 8'hFF && r.ds3 == 8'h80 && r.cnt == 12'h000));
  // R5
  dec_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && !wr_stb && !rd_stb) |=> (!r.ifs[5] && r.ds3 == 8'h00));
  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

endmodule

// File: rtl/cdreg_port.sv
module cdreg_port #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_ld,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [IDX_W-1:0] idx_o,
  input  logic             gate_en,
  input  logic             xfer_done,
  input  logic             dec_done,
  input  logic [31:0]      dec_hdr,
  input  logic [31:0]      dec_sub,
  output logic             xfer_start,
  output logic [11:0]      xfer_count,
  output logic [15:0]      xfer_addr,
  output logic             irq_n,
  output logic             irq_req
);

  logic [7:0] ifs_w, ifc_w;
  logic       soft_rst_w;
  logic       access_w;

  assign access_w = rd_stb || wr_stb;

  cdreg_index #(.IDX_W(IDX_W)) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (idx_ld),
    .ld_val (idx_in),
    .access (access_w),
    .clr    (soft_rst_w),
    .idx    (idx_o)
  );

  cdreg_file #(.IDX_W(IDX_W)) u_file (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx_o),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .xfer_done  (xfer_done),
    .dec_done   (dec_done),
    .dec_hdr    (dec_hdr),
    .dec_sub    (dec_sub),
    .rd_data    (rd_data),
    .ifs_o      (ifs_w),
    .ifc_o      (ifc_w),
    .cnt_o      (xfer_count),
    .adr_o      (xfer_addr),
    .xfer_start (xfer_start),
    .soft_rst   (soft_rst_w)
  );

  cdreg_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ifs     (ifs_w),
    .ifc     (ifc_w),
    .gate_en (gate_en),
    .irq_n   (irq_n),
    .irq_req (irq_req)
  );

endmodule

// File: tb/cdreg_port_tb_top.sv
`timescale 1ns/1ps
module cdreg_port_tb_top;

  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_ld = 1'b0;
  logic [IDX_W-1:0] idx_in = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [IDX_W-1:0] idx_o;
  logic gate_en = 1'b0, xfer_done = 1'b0, dec_done = 1'b0;
  logic [31:0] dec_hdr = '0, dec_sub = '0;
  logic xfer_start;
  logic [11:0] xfer_count;
  logic [15:0] xfer_addr;
  logic irq_n, irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cdreg_port #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_in(idx_in),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .idx_o(idx_o), .gate_en(gate_en), .xfer_done(xfer_done),
    .dec_done(dec_done), .dec_hdr(dec_hdr), .dec_sub(dec_sub),
    .xfer_start(xfer_start), .xfer_count(xfer_count), .xfer_addr(xfer_addr),
    .irq_n(irq_n), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input int v);
    idx_ld = 1'b1; idx_in = v[IDX_W-1:0];
    @(negedge clk);
    idx_ld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic rdreg(input int i, output logic [7:0] d);
    set_idx(i);
    rd(d);
  endtask

  task automatic wrreg(input int i, input logic [7:0] d);
    set_idx(i);
    wr(d);
  endtask

  task automatic pulse_dec(input logic [31:0] h, input logic [31:0] s);
    dec_hdr = h; dec_sub = s; dec_done = 1'b1;
    @(negedge clk);
    dec_done = 1'b0;
  endtask

  task automatic pulse_xd();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 irq_n", irq_n, 1);
    chk("R2 irq_req", irq_req, 0);
    chk("R2 rd_data", rd_data, 0);
    chk("R2 idx_o", idx_o, 0);
    chk("R2 xfer_start", xfer_start, 0);
    rdreg(1, d);  chk("R2 status", d, 8'hFF);
    rdreg(7, d);  chk("R2 head3", d, 8'h01);
    rdreg(15, d); chk("R2 ds3", d, 8'h80);

    // R1 index sweep
    for (int v = 0; v < 16; v++) begin
      set_idx(v);
      rd(d);
      chk("R1 idx step", idx_o, (v == 0) ? 0 : ((v + 1) % 16));
    end
    for (int v = 1; v < 15; v++) begin
      set_idx(v);
      chk("R1 idx load", idx_o, v);
    end

    // R13 counters, stat0, stat1, unmapped
    set_idx(2); wr(8'hAB); wr(8'hFF); wr(8'h34); wr(8'h12);
    chk("R13 count port", xfer_count, 12'hFAB);
    chk("R13 addr port", xfer_addr, 16'h1234);
    set_idx(2); rd(d); chk("R13 count low", d, 8'hAB);
    rd(d); chk("R13 count high", d, 8'h0F);
    rdreg(13, d); chk("R13 stat1", d, 8'h00);
    rdreg(0, d);  chk("R13 unmapped", d, 8'hFF);
    wrreg(10, 8'h9F);
    rdreg(12, d); chk("R13 stat0", d, 8'h80);

    // R14 hold
    rdreg(2, d);
    repeat (3) @(negedge clk);
    chk("R14 hold", rd_data, 8'hAB);

    // R5 / R8 decoder capture and acknowledge
    wrreg(10, 8'h80);
    pulse_dec(32'h44332211, 32'h88776655);
    rdreg(1, d);  chk("R5 dec pending", d, 8'hDF);
    rdreg(15, d); chk("R8 ds3 first", d, 8'h00);
    rdreg(1, d);  chk("R8 dec cleared", d, 8'hFF);
    rdreg(15, d); chk("R8 ds3 second", d, 8'h80);

    // R11 header select
    wrreg(11, 8'h00);
    set_idx(4);
    for (int k = 0; k < 4; k++) begin
      rd(d); chk("R11 main byte", d, (32'h44332211 >> (8 * k)) & 32'hFF);
    end
    wrreg(11, 8'h01);
    set_idx(4);
    for (int k = 0; k < 4; k++) begin
      rd(d); chk("R11 sub byte", d, (32'h88776655 >> (8 * k)) & 32'hFF);
    end

    // R5 ignored when decode disabled
    wrreg(11, 8'h00);
    wrreg(10, 8'h00);
    pulse_dec(32'hDEADBEEF, 32'h0);
    rdreg(1, d); chk("R5 ignored status", d, 8'hFF);
    rdreg(4, d); chk("R5 ignored header", d, 8'h11);

    // R12 stat2 sweep
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++) begin
          wrreg(10, 8'h80);
          pulse_dec(32'h0, (s << 21));
          set_idx(10);
          wr(8'h80 | (a << 4));
          wr(m << 2);
          rdreg(14, d);
          chk("R12 stat2", d, a ? ((((m >> 1) & 1) << 3) | (s << 2)) : (m << 2));
          rdreg(15, d);
        end

    // R10 soft reset
    wrreg(2, 8'h55);
    wrreg(15, 8'h00);
    chk("R10 idx", idx_o, 0);
    chk("R10 count", xfer_count, 0);
    rdreg(1, d);  chk("R10 status", d, 8'hFF);
    rdreg(12, d); chk("R10 stat0", d, 8'h00);

    // R3 / R4 trigger, abort, done
    wrreg(1, 8'h02);
    set_idx(6); wr(8'h00);
    chk("R3 start pulse", xfer_start, 1);
    @(negedge clk);
    chk("R3 start one clock", xfer_start, 0);
    rdreg(1, d); chk("R3 busy", d, 8'hF5);
    pulse_xd();
    rdreg(1, d); chk("R4 done", d, 8'hBF);
    wrreg(7, 8'h00);
    rdreg(1, d); chk("R9 ack", d, 8'hFF);
    set_idx(6); wr(8'h00);
    wrreg(1, 8'h00);
    rdreg(1, d); chk("R3 abort", d, 8'hFF);
    set_idx(6); wr(8'h00);
    chk("R3 trigger ignored", xfer_start, 0);
    rdreg(1, d); chk("R3 ignored status", d, 8'hFF);

    // R7 pulse timing
    gate_en = 1'b1;
    wrreg(1, 8'h62);
    pulse_xd();
    chk("R6 irq_n low", irq_n, 0);
    chk("R7 not yet", irq_req, 0);
    @(negedge clk);
    chk("R7 pulse", irq_req, 1);
    @(negedge clk);
    chk("R7 one clock", irq_req, 0);
    wrreg(7, 8'h00);
    chk("R9 irq released", irq_n, 1);
    gate_en = 1'b0;
    pulse_xd();
    @(negedge clk);
    chk("R7 gated off", irq_req, 0);
    wrreg(7, 8'h00);

    // R6 enable x pending matrix
    for (int en = 0; en < 4; en++)
      for (int p = 0; p < 4; p++) begin
        wrreg(15, 8'h00);
        wrreg(1, ((en & 2) << 5) | ((en & 1) << 5) | 8'h02);
        wrreg(10, 8'h80);
        if (p & 2) pulse_xd();
        if (p & 1) pulse_dec(32'h0, 32'h0);
        chk("R6 irq matrix", irq_n, ((en & p) != 0) ? 0 : 1);
      end

    summary();
    $finish;
  end

endmodule